// File: doc/BRIEF.md
# NAND Command Descriptor Sequencer

This block sits between a host register port and a NAND strobe timing generator. Software sets a run enable. The block then raises a request for a command descriptor and takes exactly three 32-bit words, in order, through a single write port. The first word describes the operation: its kind, its opcode bytes, how many address bytes to send, whether a second opcode follows, and whether the chip status is to be polled automatically. The other two words supply the address bytes.

Once the descriptor is complete, the block issues one bus phase at a time to the downstream timing generator. The phases are first opcode, address bytes, an optional second opcode, a data burst, and an optional status poll. Each phase is held on a valid/acknowledge handshake until it is accepted. When the last phase is accepted, the block sets one of three sticky completion flags: command done, page done or bad-block detect. Each flag stays set until software clears it.

Top module: `nand_cmd_sequencer`

## Requirements
- R1: After reset, wcmd_req, ph_valid, ph_cs, cmd_done, page_done and bad_blk are all 0.
- R2: wcmd_req rises on the first clock edge that samples run_en high while the block is idle. Word writes made while wcmd_req is low are ignored, and wcmd_req is never high together with ph_valid.
- R3: Exactly three words are accepted while wcmd_req is high, in the order descriptor, address word A, address word B. The descriptor fields are decoded as follows:
  - bit 25: auto status poll
  - bit 24: chip select, driven on ph_cs during phases
  - bits 23:21: operation (0 read, 1 program, 2 erase, 3 read ID, 4 read status, 5 reset/lock/unlock; 6 and 7 behave as 5)
  - bit 19: second-opcode enable
  - bits 18:16: address byte count
  - bits 15:8: second opcode
  - bits 7:0: first opcode
  - bit 20 and bits 31:26 have no effect.
- R4: Phases are issued in this order. Each kind is encoded on ph_kind as shown.
  - First opcode: code 0, byte = bits 7:0.
  - The address bytes, code 1, as many as bits 18:16 give. They are taken least-significant byte first from word A, then from word B.
  - For every operation except program, the second opcode (code 0) when bit 19 is set.
  - Then the data phase, if the operation has one.
- R5: A program sends its write-data phase (code 3) right after the address bytes. The second opcode, when enabled, follows the data.
- R6: ph_len carries the byte count of a data phase and is 0 for every other phase. The counts are:
  - Read (data code 2) and program: 2112 for a large page without ECC, 2088 with ECC, 528 for a small page without ECC and 520 with ECC.
  - Read ID and read status: an 8-byte read (code 2).
  - Erase, reset and types 6/7: no data phase.
- R7: When bit 25 is set, the last phase is a status poll (code 4, byte 0x70). If stat_fail is high when that poll is acknowledged, bad_blk is set instead of cmd_done.
- R8: When the final phase of a read is acknowledged, page_done is set. For every other operation cmd_done is set, unless R7 selects bad_blk. Exactly one flag is set per command.
- R9: run_en low at a clock edge returns the block to idle on that edge and discards partly loaded words. The flags are left unchanged.
- R10: Each flag stays set until its flag_clr bit is 1 at a clock edge (bit 0 cmd_done, bit 1 page_done, bit 2 bad_blk). A set on the same edge wins over a clear.
- R11: While ph_valid is high and ph_ack is low, ph_kind, ph_byte and ph_len hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run enable; low aborts to idle |
| wr_valid | input | 1 | Descriptor word write strobe |
| wr_data | input | 32 | Descriptor word |
| large_page | input | 1 | 1: 2048-byte page, 0: 512-byte page |
| ecc_en | input | 1 | ECC on: the spare transfer is shortened |
| wcmd_req | output | 1 | Ready to accept descriptor words |
| ph_valid | output | 1 | A bus phase is offered |
| ph_kind | output | 3 | Phase kind code |
| ph_byte | output | 8 | Opcode or address byte of the phase |
| ph_len | output | LEN_W | Data byte count of a data phase |
| ph_cs | output | 1 | Chip select from the descriptor |
| ph_ack | input | 1 | Timing generator accepted the phase |
| stat_fail | input | 1 | Failure bit of the polled status |
| flag_clr | input | 3 | Flag clear strobes |
| cmd_done | output | 1 | Sticky command-done flag |
| page_done | output | 1 | Sticky page-done flag |
| bad_blk | output | 1 | Sticky bad-block flag |

## Verification
The hardest cases to reach from the ports are an abort that lands in the middle of a long multi-phase program, and a descriptor load that is cut short after two words. The stimulus holds back the acknowledge for several cycles so the sequence can be caught inside its write-data phase, and drops run_en there. It also drops run_en after a partial load, then loads a fresh descriptor, so that any stale word left behind would change the phase stream. A behavioural model rebuilds the expected phase list from the three words and follows every handshake, so address byte order and second-opcode placement are checked on every cycle.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

   // decoded descriptor word, packed MSB first
   typedef struct packed {
      logic       auto_rs;
      logic       cs;
      logic [2:0] op;
      logic       dbc;
      logic [2:0] naddr;
      logic [7:0] c2;
      logic [7:0] c1;
   } desc_t;

   localparam logic [2:0] OP_READ  = 3'd0;
   localparam logic [2:0] OP_PROG  = 3'd1;
   localparam logic [2:0] OP_ERASE = 3'd2;
   localparam logic [2:0] OP_RDID  = 3'd3;
   localparam logic [2:0] OP_RDST  = 3'd4;

   typedef enum logic [2:0] {
      PK_CMD   = 3'd0,
      PK_ADDR  = 3'd1,
      PK_RDATA = 3'd2,
      PK_WDATA = 3'd3,
      PK_STAT  = 3'd4
   } phase_kind_t;

   function automatic logic op_has_data(input logic [2:0] op);
      return (op == OP_READ) || (op == OP_PROG) || (op == OP_RDID) || (op == OP_RDST);
   endfunction

endpackage

// File: rtl/nand_desc_loader.sv
module nand_desc_loader
   import nand_seq_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int N_WORDS = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          take_en,
   input  logic                          wr_valid,
   input  logic [WORD_W-1:0]             wr_data,
   output desc_t                         desc,
   output logic [(N_WORDS-1)*WORD_W-1:0] addr_bytes,
   output logic                          last_word
);
   localparam int CNT_W = $clog2(N_WORDS + 1);

   if (WORD_W < 26) begin : g_bad_width
      $error("descriptor word narrower than its fields");
   end
   if (N_WORDS < 2) begin : g_bad_count
      $error("descriptor needs at least one address word");
   end

   logic [CNT_W-1:0] cnt;
   logic             take;

   assign take      = take_en && wr_valid;
   assign last_word = take && (cnt == CNT_W'(N_WORDS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!take_en) begin
         cnt <= '0;
      end else if (take) begin
         cnt <= last_word ? '0 : cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         desc <= '0;
      end else if (take && cnt == '0) begin
         desc.auto_rs <= wr_data[25];
         desc.cs      <= wr_data[24];
         desc.op      <= wr_data[23:21];
         desc.dbc     <= wr_data[19];
         desc.naddr   <= wr_data[18:16];
         desc.c2      <= wr_data[15:8];
         desc.c1      <= wr_data[7:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_bytes <= '0;
      end else begin
         for (int i = 1; i < N_WORDS; i++) begin
            if (take && cnt == CNT_W'(i))
               addr_bytes[(i-1)*WORD_W +: WORD_W] <= wr_data;
         end
      end
   end

endmodule

// File: rtl/nand_phase_seq.sv
module nand_phase_seq
   import nand_seq_pkg::*;
#(
   parameter int         ADDR_W       = 64,
   parameter int         LEN_W        = 12,
   parameter int         LG_PAGE      = 2048,
   parameter int         LG_SPARE     = 64,
   parameter int         LG_ECC_SPARE = 40,
   parameter int         SM_PAGE      = 512,
   parameter int         SM_SPARE     = 16,
   parameter int         SM_ECC_SPARE = 8,
   parameter int         ID_BYTES     = 8,
   parameter logic [7:0] STATUS_OP    = 8'h70
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic              start,
   input  desc_t             desc,
   input  logic [ADDR_W-1:0] addr_bytes,
   input  logic              large_page,
   input  logic              ecc_en,
   input  logic              ph_ack,
   input  logic              stat_fail,
   output logic              arm,
   output logic              ph_valid,
   output logic [2:0]        ph_kind,
   output logic [7:0]        ph_byte,
   output logic [LEN_W-1:0]  ph_len,
   output logic              ph_cs,
   output logic              ev_cmd,
   output logic              ev_page,
   output logic              ev_bad
);
   localparam int AIDX_W = $clog2(ADDR_W / 8);

   if (LG_PAGE + LG_SPARE >= (1 << LEN_W)) begin : g_bad_len
      $error("LEN_W too narrow for the largest transfer");
   end
   if (LG_ECC_SPARE > LG_SPARE || SM_ECC_SPARE > SM_SPARE) begin : g_bad_spare
      $error("ECC spare count exceeds raw spare count");
   end

   typedef enum logic [2:0] {
      S_IDLE, S_LOAD, S_CMD1, S_ADDR, S_CMD2, S_DATA, S_STAT, S_FIN
   } seq_state_t;

   seq_state_t        state, nxt;
   logic [AIDX_W-1:0] aidx;
   logic [LEN_W-1:0]  data_len;
   logic              fin;

   function automatic seq_state_t tail_st();
      return desc.auto_rs ? S_STAT : S_FIN;
   endfunction

   function automatic seq_state_t after_data_st();
      return (desc.dbc && desc.op == OP_PROG) ? S_CMD2 : tail_st();
   endfunction

   function automatic seq_state_t pre_data_st();
      return op_has_data(desc.op) ? S_DATA : after_data_st();
   endfunction

   function automatic seq_state_t after_addr_st();
      return (desc.dbc && desc.op != OP_PROG) ? S_CMD2 : pre_data_st();
   endfunction

   always_comb begin
      case (state)
         S_CMD1:  nxt = (desc.naddr != 3'd0) ? S_ADDR : after_addr_st();
         S_ADDR:  nxt = (aidx == AIDX_W'(desc.naddr - 3'd1)) ? after_addr_st() : S_ADDR;
         S_CMD2:  nxt = (desc.op == OP_PROG) ? tail_st() : pre_data_st();
         S_DATA:  nxt = after_data_st();
         S_STAT:  nxt = S_FIN;
         default: nxt = state;
      endcase
   end

   always_comb begin
      if (desc.op == OP_RDID || desc.op == OP_RDST)
         data_len = LEN_W'(ID_BYTES);
      else if (large_page)
         data_len = ecc_en ? LEN_W'(LG_PAGE + LG_ECC_SPARE) : LEN_W'(LG_PAGE + LG_SPARE);
      else
         data_len = ecc_en ? LEN_W'(SM_PAGE + SM_ECC_SPARE) : LEN_W'(SM_PAGE + SM_SPARE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE;
         aidx  <= '0;
      end else if (!run_en) begin
         state <= S_IDLE;
         aidx  <= '0;
      end else begin
         case (state)
            S_IDLE: state <= S_LOAD;
            S_LOAD: if (start) state <= S_CMD1;
            default: begin
               if (ph_ack) begin
                  state <= (nxt == S_FIN) ? S_IDLE : nxt;
                  aidx  <= (state == S_ADDR) ? aidx + 1'b1 : '0;
               end
            end
         endcase
      end
   end

   assign arm      = (state == S_LOAD);
   assign ph_valid = (state == S_CMD1) || (state == S_ADDR) || (state == S_CMD2) ||
                     (state == S_DATA) || (state == S_STAT);
   assign ph_cs    = ph_valid && desc.cs;

   always_comb begin
      ph_kind = PK_CMD;
      ph_byte = 8'h00;
      ph_len  = '0;
      case (state)
         S_CMD1: ph_byte = desc.c1;
         S_ADDR: begin
            ph_kind = PK_ADDR;
            ph_byte = addr_bytes[aidx*8 +: 8];
         end
         S_CMD2: ph_byte = desc.c2;
         S_DATA: begin
            ph_kind = (desc.op == OP_PROG) ? PK_WDATA : PK_RDATA;
            ph_len  = data_len;
         end
         S_STAT: begin
            ph_kind = PK_STAT;
            ph_byte = STATUS_OP;
         end
         default: ;
      endcase
   end

   assign fin     = run_en && ph_valid && ph_ack && (nxt == S_FIN);
   assign ev_page = fin && (desc.op == OP_READ);
   assign ev_bad  = fin && (desc.op != OP_READ) && (state == S_STAT) && stat_fail;
   assign ev_cmd  = fin && !ev_page && !ev_bad;

endmodule

// File: rtl/nand_event_flags.sv
module nand_event_flags #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] q
);
   for (genvar gi = 0; gi < N; gi++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       q[gi] <= 1'b0;
         else if (set[gi]) q[gi] <= 1'b1;
         else if (clr[gi]) q[gi] <= 1'b0;
      end
   end
endmodule

// File: rtl/nand_cmd_sequencer.sv
module nand_cmd_sequencer
   import nand_seq_pkg::*;
#(
   parameter int         WORD_W       = 32,
   parameter int         LEN_W        = 12,
   parameter int         LG_PAGE      = 2048,
   parameter int         LG_SPARE     = 64,
   parameter int         LG_ECC_SPARE = 40,
   parameter int         SM_PAGE      = 512,
   parameter int         SM_SPARE     = 16,
   parameter int         SM_ECC_SPARE = 8,
   parameter int         ID_BYTES     = 8,
   parameter logic [7:0] STATUS_OP    = 8'h70
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_en,
   input  logic              wr_valid,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              large_page,
   input  logic              ecc_en,
   output logic              wcmd_req,
   output logic              ph_valid,
   output logic [2:0]        ph_kind,
   output logic [7:0]        ph_byte,
   output logic [LEN_W-1:0]  ph_len,
   output logic              ph_cs,
   input  logic              ph_ack,
   input  logic              stat_fail,
   input  logic [2:0]        flag_clr,
   output logic              cmd_done,
   output logic              page_done,
   output logic              bad_blk
);
   localparam int N_WORDS = 3;
   localparam int ADDR_W  = (N_WORDS - 1) * WORD_W;

   desc_t             desc;
   logic [ADDR_W-1:0] addr_bytes;
   logic              last_word;
   logic              arm;
   logic              ev_cmd, ev_page, ev_bad;
   logic [2:0]        flags;

   nand_desc_loader #(.WORD_W(WORD_W), .N_WORDS(N_WORDS)) u_loader (
      .clk        (clk),
      .rst_n      (rst_n),
      .take_en    (arm && run_en),
      .wr_valid   (wr_valid),
      .wr_data    (wr_data),
      .desc       (desc),
      .addr_bytes (addr_bytes),
      .last_word  (last_word)
   );

   nand_phase_seq #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W),
      .LG_PAGE(LG_PAGE), .LG_SPARE(LG_SPARE), .LG_ECC_SPARE(LG_ECC_SPARE),
      .SM_PAGE(SM_PAGE), .SM_SPARE(SM_SPARE), .SM_ECC_SPARE(SM_ECC_SPARE),
      .ID_BYTES(ID_BYTES), .STATUS_OP(STATUS_OP)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_en     (run_en),
      .start      (last_word),
      .desc       (desc),
      .addr_bytes (addr_bytes),
      .large_page (large_page),
      .ecc_en     (ecc_en),
      .ph_ack     (ph_ack),
      .stat_fail  (stat_fail),
      .arm        (arm),
      .ph_valid   (ph_valid),
      .ph_kind    (ph_kind),
      .ph_byte    (ph_byte),
      .ph_len     (ph_len),
      .ph_cs      (ph_cs),
      .ev_cmd     (ev_cmd),
      .ev_page    (ev_page),
      .ev_bad     (ev_bad)
   );

   nand_event_flags #(.N(3)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   ({ev_bad, ev_page, ev_cmd}),
      .clr   (flag_clr),
      .q     (flags)
   );

   assign wcmd_req  = arm;
   assign cmd_done  = flags[0];
   assign page_done = flags[1];
   assign bad_blk   = flags[2];

endmodule

// File: rtl/nand_cmd_sequencer_chk.sv
module nand_cmd_sequencer_chk #(
   parameter int LEN_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_en,
   input logic             wcmd_req,
   input logic             ph_valid,
   input logic [2:0]       ph_kind,
   input logic [7:0]       ph_byte,
   input logic [LEN_W-1:0] ph_len,
   input logic             ph_ack,
   input logic [2:0]       flag_clr,
   input logic             cmd_done,
   input logic             page_done,
   input logic             bad_blk
);
   assert_req_not_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wcmd_req |-> !ph_valid);

   assert_stop_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (!ph_valid && !wcmd_req));

   assert_phase_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_valid && !ph_ack && run_en) |=>
         (ph_valid && $stable(ph_kind) && $stable(ph_byte) && $stable(ph_len)));

   assert_len_only_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_valid && (ph_kind == 3'd2 || ph_kind == 3'd3)) |-> (ph_len != '0));

   assert_len_zero_other_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_valid && ph_kind != 3'd2 && ph_kind != 3'd3) |-> (ph_len == '0));

   assert_one_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({$rose(cmd_done), $rose(page_done), $rose(bad_blk)}) <= 1);

   assert_flag_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cmd_done) || $rose(page_done) || $rose(bad_blk)) |-> $past(ph_valid && ph_ack));

   assert_sticky_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_done && !flag_clr[0]) |=> cmd_done);

   assert_sticky_page_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (page_done && !flag_clr[1]) |=> page_done);

   assert_sticky_bad_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bad_blk && !flag_clr[2]) |=> bad_blk);
endmodule

bind nand_cmd_sequencer nand_cmd_sequencer_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/nand_cmd_sequencer_tb.sv
module nand_cmd_sequencer_tb;
   localparam int CLK_PERIOD = 10;
   localparam int LEN_W      = 12;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             run_en, wr_valid, large_page, ecc_en, ph_ack, stat_fail;
   logic [31:0]      wr_data;
   logic [2:0]       flag_clr;
   logic             wcmd_req, ph_valid, ph_cs, cmd_done, page_done, bad_blk;
   logic [2:0]       ph_kind;
   logic [7:0]       ph_byte;
   logic [LEN_W-1:0] ph_len;

   int    checks = 0;
   int    failures = 0;
   int    ack_lat = 0;
   bit    cmp_on = 0;
   string cur = "R1";

   nand_cmd_sequencer u_dut (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .wr_valid(wr_valid), .wr_data(wr_data),
      .large_page(large_page), .ecc_en(ecc_en), .wcmd_req(wcmd_req), .ph_valid(ph_valid),
      .ph_kind(ph_kind), .ph_byte(ph_byte), .ph_len(ph_len), .ph_cs(ph_cs), .ph_ack(ph_ack),
      .stat_fail(stat_fail), .flag_clr(flag_clr), .cmd_done(cmd_done),
      .page_done(page_done), .bad_blk(bad_blk)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // ---------------- behavioural reference model ----------------
   typedef struct packed {
      logic [2:0]       kind;
      logic [7:0]       byt;
      logic [LEN_W-1:0] len;
   } exp_ph_t;

   exp_ph_t     q[$];
   int          mst = 0;   // 0 idle, 1 loading, 2 phases
   int          mcnt = 0;
   logic [31:0] mw [3];
   logic [2:0]  mflags = 3'b000;

   function automatic int exp_len(int op);
      if (op == 3 || op == 4) return 8;
      if (large_page) return ecc_en ? 2088 : 2112;
      return ecc_en ? 520 : 528;
   endfunction

   task automatic build_list();
      int          op, naddr;
      bit          dbc, autos;
      logic [63:0] ab;
      op    = int'(mw[0][23:21]);
      naddr = int'(mw[0][18:16]);
      dbc   = mw[0][19];
      autos = mw[0][25];
      ab    = {mw[2], mw[1]};
      q.delete();
      q.push_back('{3'd0, mw[0][7:0], '0});
      for (int i = 0; i < naddr; i++) q.push_back('{3'd1, ab[i*8 +: 8], '0});
      if (dbc && op != 1) q.push_back('{3'd0, mw[0][15:8], '0});
      if (op == 0 || op == 1 || op == 3 || op == 4)
         q.push_back('{(op == 1) ? 3'd3 : 3'd2, 8'h00, LEN_W'(exp_len(op))});
      if (dbc && op == 1) q.push_back('{3'd0, mw[0][15:8], '0});
      if (autos) q.push_back('{3'd4, 8'h70, '0});
   endtask

   always @(posedge clk) begin
      logic [2:0] setv;
      exp_ph_t    e;
      setv = 3'b000;
      if (!rst_n) begin
         mst = 0; mcnt = 0; q.delete(); mflags = 3'b000;
      end else begin
         if (!run_en) begin
            mst = 0; mcnt = 0; q.delete();
         end else begin
            case (mst)
               0: mst = 1;
               1: if (wr_valid) begin
                     mw[mcnt] = wr_data;
                     mcnt++;
                     if (mcnt == 3) begin build_list(); mst = 2; mcnt = 0; end
                  end
               default: if (ph_ack && q.size() > 0) begin
                     e = q.pop_front();
                     if (q.size() == 0) begin
                        if (mw[0][23:21] == 3'd0)          setv[1] = 1'b1;
                        else if (e.kind == 3'd4 && stat_fail) setv[2] = 1'b1;
                        else                                setv[0] = 1'b1;
                        mst = 0;
                     end
                  end
            endcase
         end
         mflags = (mflags & ~flag_clr) | setv;
      end
   end

   // ---------------- per-cycle comparison ----------------
   initial forever begin
      @(negedge clk);
      if (rst_n && cmp_on) begin
         bit ev, ok;
         ev = (mst == 2) && (q.size() > 0);
         ok = (wcmd_req == (mst == 1)) && (ph_valid == ev) &&
              ({bad_blk, page_done, cmd_done} == mflags);
         if (ev) ok = ok && (ph_kind == q[0].kind) && (ph_byte == q[0].byt) &&
                      (ph_len == q[0].len) && (ph_cs == mw[0][24]);
         checks++;
         if (!ok) begin
            failures++;
            $display("FAIL %s cycle compare: act req=%0b v=%0b k=%0d b=%h l=%0d cs=%0b fl=%b exp req=%0b v=%0b k=%0d b=%h l=%0d cs=%0b fl=%b",
               cur, wcmd_req, ph_valid, ph_kind, ph_byte, ph_len, ph_cs,
               {bad_blk, page_done, cmd_done}, (mst == 1), ev,
               ev ? q[0].kind : 3'd0, ev ? q[0].byt : 8'h00, ev ? q[0].len : '0,
               mw[0][24], mflags);
         end
      end
   end

   // timing generator responder
   initial begin
      int waitc;
      waitc = 0;
      ph_ack = 1'b0;
      forever begin
         @(negedge clk);
         if (ph_valid && waitc >= ack_lat) begin
            ph_ack = 1'b1; waitc = 0;
         end else begin
            ph_ack = 1'b0;
            waitc = ph_valid ? waitc + 1 : 0;
         end
      end
   end

   // ---------------- helpers ----------------
   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
      end
   endtask

   task automatic chk_flags(input logic [2:0] exp, input string req);
      chk({bad_blk, page_done, cmd_done} == exp, req, "flags {bad,page,cmd}",
          int'({bad_blk, page_done, cmd_done}), int'(exp));
   endtask

   function automatic logic [31:0] mk(bit autos, bit cs, int op, bit dbc, int naddr,
                                      logic [7:0] c2, logic [7:0] c1);
      return {6'b0, autos, cs, 3'(op), 1'b0, dbc, 3'(naddr), c2, c1};
   endfunction

   task automatic clear_flags();
      flag_clr = 3'b111; @(negedge clk); flag_clr = 3'b000;
   endtask

   task automatic wait_req();
      @(negedge clk);
      for (int i = 0; i < 10 && !wcmd_req; i++) @(negedge clk);
   endtask

   task automatic load3(input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2);
      wr_valid = 1'b1; wr_data = w0; @(negedge clk);
      wr_data = w1; @(negedge clk);
      wr_data = w2; @(negedge clk);
      wr_valid = 1'b0;
   endtask

   task automatic issue(input string tag, input logic [31:0] w0, input logic [31:0] w1,
                        input logic [31:0] w2);
      cur = tag;
      run_en = 1'b1;
      wait_req();
      load3(w0, w1, w2);
      for (int i = 0; i < 300 && ph_valid; i++) @(negedge clk);
      run_en = 1'b0;
      @(negedge clk);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      rst_n = 1'b0; run_en = 1'b0; wr_valid = 1'b0; wr_data = '0;
      large_page = 1'b1; ecc_en = 1'b0; stat_fail = 1'b0; flag_clr = 3'b000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(!wcmd_req && !ph_valid && !ph_cs, "R1", "request/valid/cs after reset",
          int'({wcmd_req, ph_valid, ph_cs}), 0);
      chk_flags(3'b000, "R1");
      cmp_on = 1;

      // R2 writes while stopped or before the request are ignored
      cur = "R2";
      wr_valid = 1'b1; wr_data = mk(0, 0, 5, 0, 0, 8'h00, 8'hEE);
      repeat (2) @(negedge clk);
      run_en = 1'b1;           // same cycle: still idle, word must be dropped
      @(negedge clk);
      wr_valid = 1'b0;
      chk(wcmd_req == 1'b1, "R2", "request one edge after run", int'(wcmd_req), 1);
      run_en = 1'b0; @(negedge clk);
      chk(wcmd_req == 1'b0, "R2", "request drops with run", int'(wcmd_req), 0);

      // R4 large-page read, two opcodes, five address bytes
      ack_lat = 1;
      issue("R4", mk(0, 0, 0, 1, 5, 8'h30, 8'h00), 32'hA1B2C3D4, 32'h000000E5);
      chk_flags(3'b010, "R8");

      // R6 read lengths for each geometry
      clear_flags();
      large_page = 1'b0; ecc_en = 1'b1; ack_lat = 0;
      issue("R6", mk(0, 0, 0, 0, 4, 8'h00, 8'h00), 32'h44332211, 32'h0);
      chk_flags(3'b010, "R6");
      large_page = 1'b1;
      issue("R6", mk(0, 0, 0, 1, 4, 8'h30, 8'h00), 32'h0BADF00D, 32'h0);
      large_page = 1'b0; ecc_en = 1'b0;
      issue("R6", mk(0, 0, 0, 0, 3, 8'h00, 8'h01), 32'h00665544, 32'h0);

      // R5 program with status poll
      clear_flags();
      large_page = 1'b1; ecc_en = 1'b1; ack_lat = 2; stat_fail = 1'b0;
      issue("R5", mk(1, 0, 1, 1, 5, 8'h10, 8'h80), 32'h12340000, 32'h00000056);
      chk_flags(3'b001, "R5");

      // R7 erase whose status reports failure
      clear_flags();
      stat_fail = 1'b1;
      issue("R7", mk(1, 0, 2, 1, 3, 8'hD0, 8'h60), 32'h00ABCDEF, 32'h0);
      chk_flags(3'b100, "R7");
      stat_fail = 1'b0;

      // R6 short reads, R3 reset-type and undefined types with chip select
      clear_flags();
      ack_lat = 0;
      issue("R6", mk(0, 0, 3, 0, 1, 8'h00, 8'h90), 32'h0, 32'h0);
      chk_flags(3'b001, "R8");
      issue("R6", mk(0, 0, 4, 0, 0, 8'h00, 8'h70), 32'h0, 32'h0);
      issue("R3", mk(0, 1, 5, 0, 0, 8'h00, 8'hFF), 32'h0, 32'h0);
      issue("R3", mk(0, 1, 6, 1, 2, 8'h23, 8'h24), 32'h00007788, 32'h0);

      // R10 selective clear
      cur = "R10";
      issue("R10", mk(0, 0, 0, 0, 1, 8'h00, 8'h00), 32'h5, 32'h0);
      chk_flags(3'b011, "R10");
      flag_clr = 3'b010; @(negedge clk); flag_clr = 3'b000;
      chk_flags(3'b001, "R10");

      // R9 abort inside the write-data phase of a program
      ack_lat = 5; cur = "R9";
      run_en = 1'b1; wait_req();
      load3(mk(1, 0, 1, 1, 2, 8'h10, 8'h80), 32'h0000BEEF, 32'h0);
      for (int i = 0; i < 40 && !(ph_valid && ph_kind == 3'd3); i++) @(negedge clk);
      chk(ph_valid && ph_kind == 3'd3, "R9", "reached write-data phase", int'(ph_kind), 3);
      run_en = 1'b0; @(negedge clk);
      chk(!ph_valid, "R9", "phase dropped after stop", int'(ph_valid), 0);
      chk_flags(3'b001, "R9");

      // R9 partial load discarded, R11 long handshake
      run_en = 1'b1; wait_req();
      wr_valid = 1'b1; wr_data = mk(0, 0, 2, 0, 7, 8'h00, 8'h55); @(negedge clk);
      wr_data = 32'hFFFFFFFF; @(negedge clk);
      wr_valid = 1'b0; run_en = 1'b0; @(negedge clk);
      ack_lat = 3;
      issue("R11", mk(0, 0, 2, 1, 3, 8'hD0, 8'h60), 32'h00030201, 32'h0);
      chk_flags(3'b001, "R11");

      repeat (5) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule